// File: doc/BRIEF.md
# PCI Interrupt Router

This block collects the four interrupt pins (INTA to INTD, numbered 0 to 3) of eight PCI slots, slots 5 through 12. It folds them onto fourteen internal interrupt lines through a fixed wiring plan. The on-board slots each have a fixed assignment. The five expansion slots rotate their pins so that the load spreads across the shared lines.

Each internal line is then conditioned by two configuration words that arrive as input ports. One bit per line selects edge or level signalling. In level mode, a second bit per line chooses the active polarity. The conditioned lines form a registered pending vector. The CPU interrupt output is the OR of that vector. The block also reports the lowest-numbered pending line as an identifier offset by a base of 32.

Top module: `irq_route_top`

## Requirements
- R1: Pin n of slot 5 drives internal line n (n = 0..3).
- R2: Every pin of slot 6 drives internal line 4, and every pin of slot 7 drives internal line 5.
- R3: Pin n of expansion slot s (s = 8..12) drives internal line (s - 8 + n) + 6, so the lines span 6..13.
- R4: With the edge bit clear and the polarity bit set, a line is pending one clock after its input is high, and stays pending for as long as the input stays high.
- R5: With both the edge bit and the polarity bit clear, a line is pending while its input is low and not pending while its input is high.
- R6: With the edge bit set, a low-to-high change on a line makes it pending for exactly one clock. A held-high input or a falling input makes it pending for no clock.
- R7: `cpuIrq` is high exactly when at least one bit of `pending` is set.
- R8: When any line is pending, `irqIdValid` is 1 and `irqId` equals 32 plus the index of the lowest pending line. Otherwise `irqIdValid` is 0.
- R9: While `rstN` is low, `pending`, `cpuIrq` and `irqIdValid` are all 0.
- R10: Pins that share a line are ORed before conditioning. In edge mode, a second pin rising while another pin of the same line is already high produces no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotPins | input | 32 | Pin n of slot s is at bit 4*(s-5)+n, active high |
| edgeCfg | input | 14 | Per-line edge select, 1 = edge, 0 = level |
| polCfg | input | 14 | Per-line level polarity, 1 = active high, 0 = active low |
| pending | output | 14 | Registered pending vector, bit i = internal line i |
| cpuIrq | output | 1 | CPU interrupt request |
| irqId | output | 8 | 32 + index of the lowest pending line |
| irqIdValid | output | 1 | irqId holds a pending line |

## Verification
The mapping is tested by asserting every slot pin alone in active-high level mode. This separates a wrong rotation offset from a wrong slot decode, because each pin lights one bit. Level mode is then run with both polarities. Edge mode is run with a rise, a long hold, a fall and a second rise, which separates a one-clock pulse from a level follow-through. Shared-pin edges and two lines pending at once exercise the OR before conditioning and the lowest-index report.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int FIRST_SLOT = 5;
  localparam int NUM_SLOTS  = 8;
  localparam int PINS       = 4;
  localparam int NUM_PINS   = NUM_SLOTS * PINS;
  localparam int NUM_LINES  = 14;
  localparam int IRQ_BASE   = 32;
  localparam int ID_W       = 8;
  localparam int IDX_W      = $clog2(NUM_LINES);

  // strobes handed from the routing control to the conditioning datapath
  typedef struct packed {
    logic [NUM_LINES-1:0] lineRaw;
    logic [NUM_LINES-1:0] edgeMode;
    logic [NUM_LINES-1:0] wantHigh;
  } route_strobe_t;

  // internal line for a given slot and pin
  function automatic int mapLine(int slot, int pin);
    if (slot == 5)                    return pin % 4;
    else if (slot == 6)               return 4;
    else if (slot == 7)               return 5;
    else if (slot >= 8 && slot <= 12) return (slot - 8 + pin) + 6;
    else                              return pin;
  endfunction

  // mask of every slot pin that feeds a line
  function automatic logic [NUM_PINS-1:0] pinMask(int line);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS; p++) begin
        if (mapLine(FIRST_SLOT + s, p) == line) m[s*PINS + p] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
#(
  parameter int NP = NUM_PINS,
  parameter int NL = NUM_LINES
) (
  input  logic [NP-1:0]   slotPins,
  input  logic [NL-1:0]   edgeCfg,
  input  logic [NL-1:0]   polCfg,
  output route_strobe_t   strobe
);
  logic [NL-1:0] lineRaw;

  // each line is the OR of the pins wired to it; the mask is fixed at elaboration
  for (genvar l = 0; l < NL; l++) begin : g_line
    localparam logic [NP-1:0] LineMask = pinMask(l);
    assign lineRaw[l] = |(slotPins & LineMask);
  end

  always_comb begin
    strobe.lineRaw  = lineRaw;
    strobe.edgeMode = edgeCfg;
    strobe.wantHigh = polCfg;
  end
endmodule

// File: rtl/irq_route_cond.sv
module irq_route_cond
  import irq_route_pkg::*;
#(
  parameter int NL   = NUM_LINES,
  parameter int IW   = ID_W,
  parameter int BASE = IRQ_BASE
) (
  input  logic          clk,
  input  logic          rstN,
  input  route_strobe_t strobe,
  output logic [NL-1:0] pending,
  output logic          cpuIrq,
  output logic [IW-1:0] irqId,
  output logic          irqIdValid
);
  localparam int XW = $clog2(NL);

  logic [NL-1:0] lineQ;
  logic [NL-1:0] pendNext;
  logic [NL-1:0] pendQ;
  logic          cpuQ;
  logic [XW-1:0] lowIdx;

  for (genvar g = 0; g < NL; g++) begin : g_cond
    logic risen;
    logic levelOn;
    assign risen   = strobe.lineRaw[g] & ~lineQ[g];
    assign levelOn = strobe.lineRaw[g] ^ ~strobe.wantHigh[g];
    assign pendNext[g] = strobe.edgeMode[g] ? risen : levelOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= '0;
      pendQ <= '0;
      cpuQ  <= 1'b0;
    end else begin
      lineQ <= strobe.lineRaw;
      pendQ <= pendNext;
      cpuQ  <= |pendNext;
    end
  end

  always_comb begin
    lowIdx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pendQ[i]) lowIdx = XW'(i);
    end
  end

  assign pending    = pendQ;
  assign cpuIrq     = cpuQ;
  assign irqIdValid = |pendQ;
  assign irqId      = IW'(BASE) + IW'(lowIdx);
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  slotPins,
  input  logic [NUM_LINES-1:0] edgeCfg,
  input  logic [NUM_LINES-1:0] polCfg,
  output logic [NUM_LINES-1:0] pending,
  output logic                 cpuIrq,
  output logic [ID_W-1:0]      irqId,
  output logic                 irqIdValid
);
  route_strobe_t strobe;

  irq_route_map #(.NP(NUM_PINS), .NL(NUM_LINES)) uMap (
    .slotPins(slotPins),
    .edgeCfg (edgeCfg),
    .polCfg  (polCfg),
    .strobe  (strobe)
  );

  irq_route_cond #(.NL(NUM_LINES), .IW(ID_W), .BASE(IRQ_BASE)) uCond (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pending   (pending),
    .cpuIrq    (cpuIrq),
    .irqId     (irqId),
    .irqIdValid(irqIdValid)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PINS-1:0]  slotPins,
  input logic [NUM_LINES-1:0] edgeCfg,
  input logic [NUM_LINES-1:0] polCfg,
  input logic [NUM_LINES-1:0] pending,
  input logic                 cpuIrq,
  input logic [ID_W-1:0]      irqId,
  input logic                 irqIdValid
);
  // R9: reset clears the outputs
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_reset_clear: assert (pending == '0 && !cpuIrq && !irqIdValid);
    end
  end

  // R7: the CPU line tracks the pending vector
  a_r7_cpu_or: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (pending != '0));

  // R8: a valid identifier points at the lowest pending line
  a_r8_valid_match: assert property (@(posedge clk) disable iff (!rstN)
    irqIdValid == cpuIrq);
  a_r8_lowest_id: assert property (@(posedge clk) disable iff (!rstN)
    irqIdValid |-> (pending[int'(irqId) - IRQ_BASE] &&
      ((pending & ((NUM_LINES'(1) << (int'(irqId) - IRQ_BASE)) - NUM_LINES'(1))) == '0)));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
    // R6: an edge pulse lasts one clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
      ($past(edgeCfg[i]) && edgeCfg[i] && pending[i]) |=> !pending[i]);
  end

  for (genvar n = 0; n < PINS; n++) begin : g_slot5
    // R1, R4: active-high level line on slot 5 follows its pin one clock later
    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(edgeCfg[n]) && $past(polCfg[n])) |->
        (pending[n] == $past(slotPins[n])));
  end
endmodule

bind irq_route_top irq_route_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .slotPins  (slotPins),
  .edgeCfg   (edgeCfg),
  .polCfg    (polCfg),
  .pending   (pending),
  .cpuIrq    (cpuIrq),
  .irqId     (irqId),
  .irqIdValid(irqIdValid)
);

// File: tb/irq_route_top_test.sv
module irq_route_top_test;
  localparam int NL = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   slotPins = '0;
  logic [NL-1:0] edgeCfg = '0;
  logic [NL-1:0] polCfg = '1;
  logic [NL-1:0] pending;
  logic          cpuIrq;
  logic [7:0]    irqId;
  logic          irqIdValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_route_top uut (
    .clk(clk), .rstN(rstN), .slotPins(slotPins), .edgeCfg(edgeCfg),
    .polCfg(polCfg), .pending(pending), .cpuIrq(cpuIrq),
    .irqId(irqId), .irqIdValid(irqIdValid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int bitOf(int slot, int pin);
    return 4 * (slot - 5) + pin;
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    slotPins = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R9 pending", 32'(pending), 0);
    chk("R9 cpuIrq", 32'(cpuIrq), 0);
    chk("R9 valid", 32'(irqIdValid), 0);
    slotPins = '0;
    rstN = 1'b1;
    tick();
    chk("R9 idle after release", 32'(pending), 0);
  endtask

  task automatic t_slot5();
    for (int n = 0; n < 4; n++) begin
      slotPins = '0;
      slotPins[bitOf(5, n)] = 1'b1;
      tick();
      chk("R1 slot5 line", 32'(pending), 32'(1) << n);
      chk("R8 slot5 id", 32'(irqId), 32 + n);
      chk("R7 slot5 cpu", 32'(cpuIrq), 1);
    end
    slotPins = '0;
    tick();
  endtask

  task automatic t_onboard();
    for (int s = 6; s <= 7; s++) begin
      for (int n = 0; n < 4; n++) begin
        slotPins = '0;
        slotPins[bitOf(s, n)] = 1'b1;
        tick();
        chk("R2 onboard line", 32'(pending), 32'(1) << (s - 2));
      end
    end
    slotPins = '0;
    tick();
  endtask

  task automatic t_expansion();
    for (int s = 8; s <= 12; s++) begin
      for (int n = 0; n < 4; n++) begin
        slotPins = '0;
        slotPins[bitOf(s, n)] = 1'b1;
        tick();
        chk("R3 rotation line", 32'(pending), 32'(1) << ((s - 8 + n) + 6));
      end
    end
    slotPins = '0;
    tick();
    chk("R7 idle cpu", 32'(cpuIrq), 0);
    chk("R8 idle valid", 32'(irqIdValid), 0);
  endtask

  task automatic t_level();
    slotPins[bitOf(5, 1)] = 1'b1;
    tick();
    tick();
    tick();
    chk("R4 level held", 32'(pending), 32'h2);
    slotPins[bitOf(5, 1)] = 1'b0;
    tick();
    chk("R4 level drop", 32'(pending), 0);
    polCfg[2] = 1'b0;
    tick();
    chk("R5 active low idle", 32'(pending), 32'h4);
    slotPins[bitOf(5, 2)] = 1'b1;
    tick();
    chk("R5 active low driven", 32'(pending), 0);
    slotPins[bitOf(5, 2)] = 1'b0;
    polCfg[2] = 1'b1;
    tick();
    chk("R5 polarity restored", 32'(pending), 0);
  endtask

  task automatic t_edge();
    edgeCfg[4] = 1'b1;
    tick();
    slotPins[bitOf(6, 0)] = 1'b1;
    tick();
    chk("R6 rise pulse", 32'(pending), 32'h10);
    tick();
    chk("R6 pulse one clock", 32'(pending), 0);
    tick();
    tick();
    chk("R6 held no pulse", 32'(pending), 0);
    slotPins[bitOf(6, 2)] = 1'b1;
    tick();
    chk("R10 shared pin no new pulse", 32'(pending), 0);
    slotPins[bitOf(6, 0)] = 1'b0;
    slotPins[bitOf(6, 2)] = 1'b0;
    tick();
    chk("R6 fall no pulse", 32'(pending), 0);
    slotPins[bitOf(6, 3)] = 1'b1;
    tick();
    chk("R10 other shared pin rises", 32'(pending), 32'h10);
    chk("R8 edge id", 32'(irqId), 36);
    slotPins = '0;
    edgeCfg = '0;
    tick();
  endtask

  task automatic t_priority();
    slotPins[bitOf(10, 1)] = 1'b1;
    slotPins[bitOf(5, 3)] = 1'b1;
    tick();
    chk("R8 two lines vector", 32'(pending), 32'h208);
    chk("R8 lowest id", 32'(irqId), 35);
    chk("R7 cpu set", 32'(cpuIrq), 1);
    slotPins[bitOf(5, 3)] = 1'b0;
    tick();
    chk("R8 next lowest id", 32'(irqId), 41);
    slotPins = '0;
    slotPins[bitOf(12, 3)] = 1'b1;
    tick();
    chk("R8 top line id", 32'(irqId), 45);
    slotPins = '0;
    tick();
    chk("R7 cpu clear", 32'(cpuIrq), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual %0d expected done", cyc);
    finish();
  end

  initial begin
    t_reset();
    t_slot5();
    t_onboard();
    t_expansion();
    t_level();
    t_edge();
    t_priority();
    finish();
  end
endmodule